// File: doc/BRIEF.md
# Programmable Symbol-Masked NFA Array

This block runs a non-deterministic finite automaton over a stream of 8-bit symbols at one symbol per clock. The automaton is held in a small array of state elements. Each element owns an acceptance set over all 256 symbol values. An element turns active when two things hold at once. The incoming symbol must be in its set. The element must also be enabled, either by at least one predecessor that was active on the previous symbol or by its start flag. Predecessor links come from a programmable N×N connection matrix. Symbols therefore belong to states, and edges only carry enables.

Software loads the automaton while the engine is stopped (`run_en` low). The acceptance table is written one symbol at a time: one word per symbol value, with one bit per element. Connection rows are written one destination element at a time. Three flag vectors mark start elements, pick the start mode and mark report elements. Raising `run_en` opens a stream. While the stream runs, any element marked for reporting that fires pushes a report entry into a small buffer. The entry holds the vector of firing report elements and the zero-based position of the symbol in the stream. When the buffer is full, the symbol input stalls.

Top module: `nfa_array`

## Requirements
- R1: After reset, `act_vec` is 0, `rpt_valid` is 0, and `sym_ready` is 0 while `run_en` is low.
- R2: On an accepted symbol s (`sym_valid` and `sym_ready` both high), element i becomes active exactly when acceptance bit i of symbol s is set and either some predecessor j in row i was active before the symbol or the start enable of element i is set. `act_vec` shows the new value after that clock edge.
- R3: `act_vec` does not change in a cycle with `run_en` high and no symbol accepted.
- R4: A start element whose mode bit (flag address 1) is 1 is enabled on every symbol.
- R5: A start element whose mode bit is 0 is enabled only on the first symbol accepted after `run_en` rises.
- R6: Configuration writes made while `run_en` is high have no effect.
- R7: When an accepted symbol makes any report-flagged element (flag address 2) active, the buffer receives an entry. The entry's vector equals the new active vector ANDed with the report flags. `rpt_valid` is high by the next cycle, and no entry has an all-zero vector.
- R8: `rpt_ofs` is the zero-based count of symbols accepted since `run_en` last rose.
- R9: `sym_ready` equals `run_en` AND buffer not full. With DEPTH entries pending, no symbol is consumed.
- R10: Entries leave in arrival order, one per cycle with `rpt_valid` and `rpt_ready` high. A head entry that is not taken holds steady.
- R11: With `run_en` low, the active vector and the offset counter clear within one cycle, and the first-symbol condition is re-armed.
- R12: With no reports pending, the input accepts one symbol every clock cycle, however many elements are active.

Configuration selector `cfg_sel`: 0 writes the acceptance word for symbol `cfg_addr` (bit i = element i accepts it); 1 writes the predecessor row of element `cfg_addr` (bit j = element j enables it); 2 writes a flag vector picked by `cfg_addr` (0 start, 1 every-symbol mode, 2 report).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Stream running; low means idle and configurable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_addr | input | 8 | Symbol value, element index or flag select |
| cfg_data | input | N | Write data, one bit per element |
| sym_valid | input | 1 | Input symbol valid |
| sym_ready | output | 1 | Input symbol accepted this cycle when valid |
| sym_data | input | 8 | Input symbol |
| act_vec | output | N | Registered active-state vector |
| rpt_valid | output | 1 | Report entry at buffer head |
| rpt_ready | input | 1 | Consumer takes the head entry |
| rpt_vec | output | N | Firing report elements of the head entry |
| rpt_ofs | output | 32 | Stream offset of the head entry |

## Verification
An accepted symbol shows up in `act_vec` one edge later. Any report it raises shows up at the buffer head on that same edge when the buffer was empty. `sym_ready` is a direct function of the registered buffer count and `run_en`, so it moves on the edge that fills or drains the buffer. The bench drives inputs on falling edges and samples each result on the next falling edge. That puts every check half a period after the edge that produced it. Stall and drain checks are timed by counting the edges that push and pop.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  typedef enum logic [1:0] {
    CFG_ACCEPT = 2'd0,
    CFG_LINK   = 2'd1,
    CFG_FLAG   = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_sel_e;

  localparam int unsigned FLAG_START  = 0;
  localparam int unsigned FLAG_ALWAYS = 1;
  localparam int unsigned FLAG_REPORT = 2;
endpackage

// File: rtl/nfa_cfg_store.sv
module nfa_cfg_store
  import nfa_pkg::*;
#(
  parameter int unsigned N    = 16,
  parameter int unsigned SYMW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [SYMW-1:0]         wr_addr,
  input  logic [N-1:0]            wr_data,
  input  logic [SYMW-1:0]         sym,
  output logic [N-1:0]            sym_hits,
  output logic [N-1:0][N-1:0]     pred_rows,
  output logic [N-1:0]            start_flags,
  output logic [N-1:0]            always_flags,
  output logic [N-1:0]            report_flags
);
  localparam int unsigned NSYM = 1 << SYMW;
  localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(wr_sel);

  // Symbol-indexed acceptance table, one bit per element per word.
  logic [N-1:0] accept_mem [NSYM];

  always_ff @(posedge clk) begin
    if (wr_en && sel == CFG_ACCEPT)
      accept_mem[wr_addr] <= wr_data;
  end

  assign sym_hits = accept_mem[sym];

  logic [IDXW-1:0] row_idx;
  assign row_idx = wr_addr[IDXW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_rows <= '0;
    end else if (wr_en && sel == CFG_LINK && int'(row_idx) < N) begin
      pred_rows[row_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_flags  <= '0;
      always_flags <= '0;
      report_flags <= '0;
    end else if (wr_en && sel == CFG_FLAG) begin
      case (wr_addr)
        SYMW'(FLAG_START):  start_flags  <= wr_data;
        SYMW'(FLAG_ALWAYS): always_flags <= wr_data;
        SYMW'(FLAG_REPORT): report_flags <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nfa_step.sv
module nfa_step #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]        act,
  input  logic [N-1:0][N-1:0] pred_rows,
  input  logic [N-1:0]        hits,
  input  logic [N-1:0]        start_en,
  output logic [N-1:0]        nxt
);
  for (genvar i = 0; i < N; i++) begin : g_elem
    logic enabled;
    assign enabled = (|(act & pred_rows[i])) | start_en[i];
    assign nxt[i]  = hits[i] & enabled;
  end
endmodule

// File: rtl/nfa_rpt_fifo.sv
module nfa_rpt_fifo #(
  parameter int unsigned W     = 48,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign head_valid = (count != '0);
  assign full       = (count == CW'(DEPTH));
  assign do_pop     = pop && head_valid;
  assign do_push    = push && (!full || do_pop);
  assign head_data  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nfa_array.sv
module nfa_array #(
  parameter int unsigned N         = 16,
  parameter int unsigned SYMW      = 8,
  parameter int unsigned OFSW      = 32,
  parameter int unsigned RPT_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [SYMW-1:0] cfg_addr,
  input  logic [N-1:0]    cfg_data,
  input  logic            sym_valid,
  output logic            sym_ready,
  input  logic [SYMW-1:0] sym_data,
  output logic [N-1:0]    act_vec,
  output logic            rpt_valid,
  input  logic            rpt_ready,
  output logic [N-1:0]    rpt_vec,
  output logic [OFSW-1:0] rpt_ofs
);
  localparam int unsigned RW = N + OFSW;

  logic [N-1:0]        hits, start_f, always_f, report_f, start_en, nxt;
  logic [N-1:0][N-1:0] pred_rows;
  logic [OFSW-1:0]     ofs;
  logic                first_sym, fire, rpt_full, rpt_push;
  logic [RW-1:0]       head;

  nfa_cfg_store #(.N(N), .SYMW(SYMW)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we && !run_en), .wr_sel(cfg_sel), .wr_addr(cfg_addr), .wr_data(cfg_data),
    .sym(sym_data), .sym_hits(hits), .pred_rows(pred_rows),
    .start_flags(start_f), .always_flags(always_f), .report_flags(report_f)
  );

  assign start_en = start_f & (always_f | {N{first_sym}});

  nfa_step #(.N(N)) u_step (
    .act(act_vec), .pred_rows(pred_rows), .hits(hits), .start_en(start_en), .nxt(nxt)
  );

  assign sym_ready = run_en && !rpt_full;
  assign fire      = sym_valid && sym_ready;
  assign rpt_push  = fire && |(nxt & report_f);

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      act_vec   <= '0;
      ofs       <= '0;
      first_sym <= 1'b1;
    end else if (fire) begin
      act_vec   <= nxt;
      ofs       <= ofs + 1'b1;
      first_sym <= 1'b0;
    end
  end

  nfa_rpt_fifo #(.W(RW), .DEPTH(RPT_DEPTH)) u_rpt (
    .clk(clk), .rst(rst),
    .push(rpt_push), .push_data({ofs, nxt & report_f}),
    .pop(rpt_ready), .head_valid(rpt_valid), .head_data(head), .full(rpt_full)
  );

  assign rpt_vec = head[N-1:0];
  assign rpt_ofs = head[RW-1:N];
endmodule

// File: rtl/nfa_array_chk.sv
module nfa_array_chk #(
  parameter int unsigned N    = 16,
  parameter int unsigned OFSW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            run_en,
  input logic            sym_valid,
  input logic            sym_ready,
  input logic            rpt_full,
  input logic [N-1:0]    act_vec,
  input logic            rpt_valid,
  input logic            rpt_ready,
  input logic [N-1:0]    rpt_vec,
  input logic [OFSW-1:0] rpt_ofs
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (run_en && !(sym_valid && sym_ready)) |=> $stable(act_vec));

  assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (rpt_full || !run_en) |-> !sym_ready);

  assert_idle_clear_R11: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (act_vec == '0));

  assert_head_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_vec) && $stable(rpt_ofs)));

  assert_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> (rpt_vec != '0));
endmodule

bind nfa_array nfa_array_chk #(.N(N), .OFSW(OFSW)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .sym_valid(sym_valid), .sym_ready(sym_ready),
  .rpt_full(rpt_full), .act_vec(act_vec), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
  .rpt_vec(rpt_vec), .rpt_ofs(rpt_ofs)
);

// File: tb/nfa_array_bench.sv
module nfa_array_bench;
  localparam int unsigned N = 16;
  localparam int STEPS = 12;
  // {symbol, expected act_vec}
  localparam logic [23:0] TBL [STEPS] = '{
    {8'h78, 16'h0010}, {8'h79, 16'h0020}, {8'h61, 16'h0001}, {8'h62, 16'h0002},
    {8'h62, 16'h0002}, {8'h63, 16'h0004}, {8'h65, 16'h0008}, {8'h61, 16'h0001},
    {8'h65, 16'h0000}, {8'h78, 16'h0000}, {8'h61, 16'h0001}, {8'h64, 16'h0000}
  };

  logic clk = 0, rst = 1, run_en = 0, cfg_we = 0, sym_valid = 0, rpt_ready = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_addr = 0, sym_data = 0;
  logic [N-1:0] cfg_data = 0;
  logic sym_ready, rpt_valid;
  logic [N-1:0] act_vec, rpt_vec;
  logic [31:0] rpt_ofs;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  nfa_array u_nfa_array (
    .clk(clk), .rst(rst), .run_en(run_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_data(sym_data), .act_vec(act_vec), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_vec(rpt_vec), .rpt_ofs(rpt_ofs)
  );

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [N-1:0] accept_for(input int s);
    logic [N-1:0] m = '0;
    m[0] = (s == 8'h61);
    m[1] = (s == 8'h62);
    m[2] = (s == 8'h63) || (s == 8'h64);
    m[3] = (s == 8'h65);
    m[4] = (s == 8'h78);
    m[5] = (s == 8'h79);
    return m;
  endfunction

  task automatic cfg(input logic [1:0] s, input logic [7:0] a, input logic [N-1:0] d);
    cfg_we = 1; cfg_sel = s; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic feed(input logic [7:0] s);
    sym_data = s; sym_valid = 1;
    @(negedge clk);
    sym_valid = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 act_vec", 48'(act_vec), 48'h0);
    check("R1 rpt_valid", 48'(rpt_valid), 48'h0);
    check("R1 sym_ready", 48'(sym_ready), 48'h0);

    for (int s = 0; s < 256; s++) cfg(2'd0, 8'(s), accept_for(s));
    cfg(2'd1, 8'd1, 16'h0003);
    cfg(2'd1, 8'd2, 16'h0002);
    cfg(2'd1, 8'd3, 16'h0004);
    cfg(2'd1, 8'd5, 16'h0010);
    cfg(2'd2, 8'd0, 16'h0011);
    cfg(2'd2, 8'd1, 16'h0001);
    cfg(2'd2, 8'd2, 16'h0018);

    run_en = 1;
    @(negedge clk);
    // Table walk: R2 transitions, R4 every-symbol start, R5 first-only start, R12 throughput
    for (int k = 0; k < STEPS; k++) begin
      check("R12 ready before symbol", 48'(sym_ready), 48'h1);
      sym_data = TBL[k][23:16]; sym_valid = 1;
      @(negedge clk);
      check($sformatf("R2/R4/R5 step %0d", k), 48'(act_vec), 48'(TBL[k][15:0]));
    end
    sym_valid = 0;

    feed(8'h61);
    check("R2 a after stream", 48'(act_vec), 48'h0001);
    @(negedge clk);
    check("R3 hold idle cycle", 48'(act_vec), 48'h0001);

    // R7/R8/R10 two reports from table, in order
    check("R7 first report valid", 48'(rpt_valid), 48'h1);
    check("R7 first report vec", 48'(rpt_vec), 48'h0010);
    check("R8 first report ofs", 48'(rpt_ofs), 48'h0);
    rpt_ready = 1; @(negedge clk); rpt_ready = 0;
    check("R7 second report vec", 48'(rpt_vec), 48'h0008);
    check("R8 second report ofs", 48'(rpt_ofs), 48'h6);
    rpt_ready = 1; @(negedge clk); rpt_ready = 0;
    check("R10 buffer drained", 48'(rpt_valid), 48'h0);

    run_en = 0;
    @(negedge clk);
    check("R11 clear on idle", 48'(act_vec), 48'h0);
    check("R9 ready low when idle", 48'(sym_ready), 48'h0);

    // R6: writes while running are dropped
    run_en = 1;
    cfg(2'd0, 8'h61, 16'h0000);
    cfg(2'd2, 8'd2, 16'h0001);
    feed(8'h61);
    check("R6 accept word kept", 48'(act_vec), 48'h0001);
    check("R6 report flags kept", 48'(rpt_valid), 48'h0);

    run_en = 0;
    @(negedge clk);
    cfg(2'd2, 8'd2, 16'h0001);
    run_en = 1;
    feed(8'h78);
    check("R5 restart re-arms first", 48'(act_vec), 48'h0010);

    // R9 fill buffer with four reports, offsets 1..4
    sym_data = 8'h61; sym_valid = 1;
    repeat (4) @(negedge clk);
    check("R9 ready low when full", 48'(sym_ready), 48'h0);
    check("R2 act during stall", 48'(act_vec), 48'h0001);
    repeat (3) @(negedge clk);
    check("R9 still stalled", 48'(sym_ready), 48'h0);
    check("R10 head ofs", 48'(rpt_ofs), 48'h1);
    rpt_ready = 1; @(negedge clk); rpt_ready = 0;
    check("R9 ready after pop", 48'(sym_ready), 48'h1);
    @(negedge clk);
    sym_valid = 0;
    check("R9 full again", 48'(sym_ready), 48'h0);
    for (int k = 2; k <= 5; k++) begin
      check($sformatf("R10 order vec %0d", k), 48'(rpt_vec), 48'h0001);
      check($sformatf("R8 order ofs %0d", k), 48'(rpt_ofs), 48'(k));
      rpt_ready = 1; @(negedge clk); rpt_ready = 0;
    end
    check("R10 empty at end", 48'(rpt_valid), 48'h0);

    finish_run();
  end
endmodule